// File: doc/BRIEF.md
# DSP Bit Manipulation Unit

This unit sits beside the 36-bit accumulator path of a fixed-point signal processor and carries out the bit-level operations that the main arithmetic path does not. A single request carries a 36-bit operand, an operation code, a signed shift amount, a field descriptor (width and offset) and a 32-bit field source. The unit returns a 36-bit result, a 6-bit exponent and two flags. The operand width leaves four guard bits above a 32-bit product.

Six operations are supported:
- barrel shifts that fill with the sign bit
- barrel shifts that fill with zeros
- exponent detection, which counts redundant sign bits for block floating-point scaling
- exponent detection combined with normalisation in the same pass
- bit-field extraction
- bit-field insertion

Requests arrive on a valid/ready handshake. The result is held in an output register that stalls while the consumer is not ready.

Top module: `bmu_top`

## Requirements
- R1: Operation code 0 is a sign-filling shift. The amount is a 7-bit two's complement value: a positive amount shifts left with zero fill, and a negative amount shifts right and copies bit 35 into the vacated top bits.
- R2: Operation code 1 is a zero-filling shift. It shifts left for a positive amount and right for a negative amount, and fills the vacated bits with zeros in both directions.
- R3: A shift whose magnitude is 36 or more saturates. A left shift gives all zeros, a zero-filling right shift gives all zeros, and a sign-filling right shift gives 36 copies of bit 35.
- R4: Operation code 2 returns the operand unchanged. The exponent output holds the number of bits below bit 35 that equal bit 35 before the first bit that differs. An all-zero or all-ones operand gives 35.
- R5: Operation code 3 returns the operand shifted left by its exponent (as defined in R4), so that bits 35 and 34 differ, and gives that exponent on the exponent output. An all-zero or all-ones operand is returned unchanged with exponent 35.
- R6: Operation code 4 returns the operand bits from position offset up to offset+width-1, right-aligned and zero-extended.
- R7: Operation code 5 replaces operand bits offset to offset+width-1 with the low bits of the field source and leaves every other bit unchanged.
- R8: Field width values above 32 act as 32 and width 0 is an empty field. Any part of a field that lies above bit 35 is dropped.
- R9: The zero flag is set exactly when the 36-bit result is 0. The sign flag equals result bit 35. The exponent output is 0 for every operation other than codes 2 and 3. Codes 6 and 7 pass the operand through unchanged.
- R10: in_ready is high whenever the output register is empty or out_ready is high. An accepted request gives out_valid one clock later, and out_valid drops one clock after a transfer in which no new request is accepted.
- R11: While out_valid is high and out_ready is low, the outputs keep their values and no new request is accepted.
- R12: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Unit can accept a request |
| in_op | input | 3 | Operation code |
| in_data | input | 36 | Operand |
| in_shamt | input | 7 | Signed shift amount |
| in_fwidth | input | 6 | Field width |
| in_foff | input | 6 | Field offset |
| in_fsrc | input | 32 | Field source for insertion |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts result |
| out_data | output | 36 | Result |
| out_exp | output | 6 | Exponent / shift count |
| out_zero | output | 1 | Result is zero |
| out_neg | output | 1 | Result bit 35 |

## Verification
Some properties are checked on every cycle, on the live datapath signals:
- a right shift with sign fill keeps the sign bit
- a normalised result has differing top two bits and an exponent no greater than 35
- an extracted value has no bits above its width
- an insertion keeps every bit outside its mask
- the flags agree with the registered result
- the one-cycle latency and the hold under backpressure

Only the bench's scenarios can show that each result has the exact expected value. These scenarios cover saturated shift amounts, degenerate exponent operands, clamped widths and fields truncated at bit 35.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  localparam int DW   = 36;
  localparam int SW   = 7;
  localparam int FW   = 6;
  localparam int SRCW = 32;
  localparam int EW   = 6;
  localparam int MAXF = 32;

  typedef enum logic [2:0] {
    OP_ASH  = 3'd0,
    OP_LSH  = 3'd1,
    OP_EXP  = 3'd2,
    OP_NORM = 3'd3,
    OP_EXTR = 3'd4,
    OP_INS  = 3'd5
  } bmu_op_e;

  // Barrel shift; positive amount = left, negative = right.
  function automatic logic [DW-1:0] shift_fn(input logic [DW-1:0] d,
                                             input logic signed [SW-1:0] amt,
                                             input logic arith);
    logic signed [SW:0] a8;
    logic [SW:0] mag;
    logic fill;
    a8   = SW'(amt) == '0 ? '0 : (SW+1)'(amt);
    a8   = {amt[SW-1], amt};
    mag  = a8[SW] ? (SW+1)'(-a8) : (SW+1)'(a8);
    fill = arith & d[DW-1];
    if (!a8[SW]) begin
      shift_fn = (mag >= (SW+1)'(DW)) ? '0 : d << mag;
    end else if (mag >= (SW+1)'(DW)) begin
      shift_fn = {DW{fill}};
    end else if (arith) begin
      shift_fn = DW'($signed(d) >>> mag);
    end else begin
      shift_fn = d >> mag;
    end
  endfunction

  // Number of bits below the MSB that match it before the first change.
  function automatic logic [EW-1:0] lead_sign_fn(input logic [DW-1:0] d);
    logic run;
    logic [EW-1:0] n;
    run = 1'b1;
    n   = '0;
    for (int i = DW-2; i >= 0; i--) begin
      if (run && (d[i] == d[DW-1])) n = n + 1'b1;
      else run = 1'b0;
    end
    return n;
  endfunction

  function automatic logic [FW-1:0] clamp_width_fn(input logic [FW-1:0] w);
    return (w > FW'(MAXF)) ? FW'(MAXF) : w;
  endfunction

  // Field mask truncated at the top of the operand.
  function automatic logic [DW-1:0] field_mask_fn(input logic [FW-1:0] w,
                                                  input logic [FW-1:0] off);
    logic [2*DW-1:0] m;
    m = ((2*DW)'(1) << clamp_width_fn(w)) - (2*DW)'(1);
    m = m << off;
    return m[DW-1:0];
  endfunction
endpackage

// File: rtl/bmu_shifter.sv
module bmu_shifter
  import bmu_pkg::*;
#(
  parameter int W  = DW,
  parameter int AW = SW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 arith,
  input  logic [W-1:0]         a,
  input  logic signed [AW-1:0] amt,
  output logic [W-1:0]         res
);
  assign res = shift_fn(a, amt, arith);

  // R1: a right shift with sign fill never changes the sign bit
  a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (en && arith && amt[AW-1]) |-> (res[W-1] == a[W-1]));

  // R2: a zero-filling right shift by 36 or more leaves nothing
  a_r2_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !arith && amt[AW-1] && ($signed(amt) <= -$signed(AW'(W)))) |-> (res == '0));
endmodule

// File: rtl/bmu_expdet.sv
module bmu_expdet
  import bmu_pkg::*;
#(
  parameter int W = DW,
  parameter int E = EW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] a,
  output logic [E-1:0] cnt,
  output logic [W-1:0] norm
);
  logic degenerate;

  assign cnt        = lead_sign_fn(a);
  assign degenerate = (cnt == E'(W-1));
  assign norm       = degenerate ? a : (a << cnt);

  // R5: normalised value has differing top bits unless degenerate
  a_r5_norm_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !degenerate) |-> (norm[W-1] != norm[W-2]));

  // R4: exponent never exceeds 35
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= E'(W-1)));

  // R5: normalisation preserves the sign
  a_r5_sign_same: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (norm[W-1] == a[W-1]));
endmodule

// File: rtl/bmu_field.sv
module bmu_field
  import bmu_pkg::*;
#(
  parameter int W  = DW,
  parameter int F  = FW,
  parameter int SR = SRCW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_ext,
  input  logic          en_ins,
  input  logic [W-1:0]  a,
  input  logic [SR-1:0] src,
  input  logic [F-1:0]  width,
  input  logic [F-1:0]  off,
  output logic [W-1:0]  ext,
  output logic [W-1:0]  ins
);
  logic [2*W-1:0] wide_a;
  logic [2*W-1:0] wide_s;
  logic [W-1:0]   low_mask;
  logic [W-1:0]   pos_mask;
  logic [F-1:0]   w_eff;

  assign w_eff    = clamp_width_fn(width);
  assign low_mask = field_mask_fn(width, '0);
  assign pos_mask = field_mask_fn(width, off);
  assign wide_a   = {{W{1'b0}}, a} >> off;
  assign wide_s   = (2*W)'(src) << off;
  assign ext      = wide_a[W-1:0] & low_mask;
  assign ins      = (a & ~pos_mask) | (wide_s[W-1:0] & pos_mask);

  // R6: extracted value is confined to the field width
  a_r6_ext_width: assert property (@(posedge clk) disable iff (!rst_n)
    en_ext |-> ((ext >> w_eff) == '0));

  // R7: insertion leaves bits outside the field untouched
  a_r7_ins_keep: assert property (@(posedge clk) disable iff (!rst_n)
    en_ins |-> (((ins ^ a) & ~pos_mask) == '0));
endmodule

// File: rtl/bmu_top.sv
module bmu_top
  import bmu_pkg::*;
#(
  parameter int W  = DW,
  parameter int A  = SW,
  parameter int F  = FW,
  parameter int SR = SRCW,
  parameter int E  = EW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2:0]          in_op,
  input  logic [W-1:0]        in_data,
  input  logic signed [A-1:0] in_shamt,
  input  logic [F-1:0]        in_fwidth,
  input  logic [F-1:0]        in_foff,
  input  logic [SR-1:0]       in_fsrc,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic [E-1:0]        out_exp,
  output logic                out_zero,
  output logic                out_neg
);
  logic          accept;
  logic [W-1:0]  sh_res;
  logic [W-1:0]  norm_res;
  logic [E-1:0]  exp_cnt;
  logic [W-1:0]  ext_res;
  logic [W-1:0]  ins_res;
  logic [W-1:0]  nxt_data;
  logic [E-1:0]  nxt_exp;
  logic          is_shift;
  logic          is_exp;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign is_shift = (in_op == OP_ASH) || (in_op == OP_LSH);
  assign is_exp   = (in_op == OP_EXP) || (in_op == OP_NORM);

  bmu_shifter #(.W(W), .AW(A)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(accept && is_shift),
    .arith(in_op == OP_ASH), .a(in_data), .amt(in_shamt), .res(sh_res)
  );

  bmu_expdet #(.W(W), .E(E)) u_exp (
    .clk(clk), .rst_n(rst_n), .en(accept && is_exp),
    .a(in_data), .cnt(exp_cnt), .norm(norm_res)
  );

  bmu_field #(.W(W), .F(F), .SR(SR)) u_field (
    .clk(clk), .rst_n(rst_n),
    .en_ext(accept && (in_op == OP_EXTR)), .en_ins(accept && (in_op == OP_INS)),
    .a(in_data), .src(in_fsrc), .width(in_fwidth), .off(in_foff),
    .ext(ext_res), .ins(ins_res)
  );

  always_comb begin
    nxt_exp = '0;
    case (in_op)
      OP_ASH, OP_LSH: nxt_data = sh_res;
      OP_EXP:  begin nxt_data = in_data;  nxt_exp = exp_cnt; end
      OP_NORM: begin nxt_data = norm_res; nxt_exp = exp_cnt; end
      OP_EXTR: nxt_data = ext_res;
      OP_INS:  nxt_data = ins_res;
      default: nxt_data = in_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_exp   <= '0;
      out_zero  <= 1'b0;
      out_neg   <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= nxt_data;
        out_exp  <= nxt_exp;
        out_zero <= (nxt_data == '0);
        out_neg  <= nxt_data[W-1];
      end
    end
  end

  // R10: result appears one clock after acceptance
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R11: stalled output holds its value
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_exp)));

  // R9: flags agree with the registered result
  a_r9_flags: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_zero == (out_data == '0)) && (out_neg == out_data[W-1])));
endmodule

// File: tb/tb_bmu_top.sv
module tb_bmu_top;
  typedef struct packed {
    logic [2:0]         op;
    logic [35:0]        d;
    logic signed [6:0]  amt;
    logic [5:0]         w;
    logic [5:0]         off;
    logic [31:0]        src;
    logic [35:0]        res;
    logic [5:0]         ex;
    logic [7:0]         req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 36'h0_0000_00F1,  7'sd4,  6'd0, 6'd0, 32'h0, 36'h0_0000_0F10, 6'd0, 8'd1},  // R1 left
    '{3'd0, 36'h8_0000_0010, -7'sd4,  6'd0, 6'd0, 32'h0, 36'hF_8000_0001, 6'd0, 8'd1},  // R1 right sign fill
    '{3'd1, 36'h8_0000_0010, -7'sd4,  6'd0, 6'd0, 32'h0, 36'h0_8000_0001, 6'd0, 8'd2},  // R2 zero fill
    '{3'd1, 36'h0_0000_0003,  7'sd2,  6'd0, 6'd0, 32'h0, 36'h0_0000_000C, 6'd0, 8'd2},  // R2 left
    '{3'd0, 36'h8_0000_0000, -7'sd40, 6'd0, 6'd0, 32'h0, 36'hF_FFFF_FFFF, 6'd0, 8'd3},  // R3 sat right
    '{3'd1, 36'hF_FFFF_FFFF,  7'sd40, 6'd0, 6'd0, 32'h0, 36'h0,           6'd0, 8'd3},  // R3 sat left
    '{3'd1, 36'hF_FFFF_FFFF, -7'sd64, 6'd0, 6'd0, 32'h0, 36'h0,           6'd0, 8'd3},  // R3 most negative
    '{3'd2, 36'h0_0000_0001,  7'sd0,  6'd0, 6'd0, 32'h0, 36'h0_0000_0001, 6'd34, 8'd4}, // R4
    '{3'd2, 36'h0,            7'sd0,  6'd0, 6'd0, 32'h0, 36'h0,           6'd35, 8'd4}, // R4 zero
    '{3'd3, 36'hF_FFFF_FF00,  7'sd0,  6'd0, 6'd0, 32'h0, 36'h8_0000_0000, 6'd27, 8'd5}, // R5 negative
    '{3'd3, 36'h0_0000_1234,  7'sd0,  6'd0, 6'd0, 32'h0, 36'h4_8D00_0000, 6'd22, 8'd5}, // R5 positive
    '{3'd3, 36'hF_FFFF_FFFF,  7'sd0,  6'd0, 6'd0, 32'h0, 36'hF_FFFF_FFFF, 6'd35, 8'd5}, // R5 degenerate
    '{3'd4, 36'h0_0000_0AB0,  7'sd0,  6'd8, 6'd4, 32'h0, 36'h0_0000_00AB, 6'd0, 8'd6},  // R6
    '{3'd4, 36'hA_0000_0000,  7'sd0,  6'd8, 6'd32, 32'h0, 36'h0_0000_000A, 6'd0, 8'd8}, // R8 truncated
    '{3'd4, 36'hF_FFFF_FFFF,  7'sd0,  6'd40, 6'd0, 32'h0, 36'h0_FFFF_FFFF, 6'd0, 8'd8}, // R8 clamp
    '{3'd5, 36'hF_FFFF_FFFF,  7'sd0,  6'd4, 6'd8, 32'h5, 36'hF_FFFF_F5FF, 6'd0, 8'd7},  // R7
    '{3'd5, 36'h0,            7'sd0,  6'd8, 6'd32, 32'hFF, 36'hF_0000_0000, 6'd0, 8'd8} // R8 insert past top
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [35:0] in_data = '0;
  logic signed [6:0] in_shamt = '0;
  logic [5:0]  in_fwidth = '0;
  logic [5:0]  in_foff = '0;
  logic [31:0] in_fsrc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;
  logic [5:0]  out_exp;
  logic        out_zero;
  logic        out_neg;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bmu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_data(in_data), .in_shamt(in_shamt), .in_fwidth(in_fwidth),
    .in_foff(in_foff), .in_fsrc(in_fsrc), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_exp(out_exp), .out_zero(out_zero), .out_neg(out_neg)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_op = v.op; in_data = v.d; in_shamt = v.amt;
    in_fwidth = v.w; in_foff = v.off; in_fsrc = v.src;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid", 64'(out_valid), 64'd0);
    check("R12 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec%0d valid", VECS[i].req, i), 64'(out_valid), 64'd1);
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), 64'(out_data), 64'(VECS[i].res));
      check($sformatf("R%0d vec%0d exp", VECS[i].req, i), 64'(out_exp), 64'(VECS[i].ex));
      // R9: flags derived from the expected result
      check($sformatf("R9 vec%0d zero", i), 64'(out_zero), 64'(VECS[i].res == 36'h0));
      check($sformatf("R9 vec%0d neg", i), 64'(out_neg), 64'(VECS[i].res[35]));
    end

    // R9: pass-through opcodes
    drive(VECS[1]); in_op = 3'd7; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 passthrough", 64'(out_data), 64'h8_0000_0010);
    check("R9 passthrough exp", 64'(out_exp), 64'd0);

    // R10: output empties with no new request
    @(negedge clk);
    check("R10 valid drops", 64'(out_valid), 64'd0);

    // R11: backpressure
    out_ready = 1'b0;
    drive(VECS[0]); in_valid = 1'b1;
    @(negedge clk);
    check("R10 valid after accept", 64'(out_valid), 64'd1);
    check("R11 in_ready low", 64'(in_ready), 64'd0);
    drive(VECS[12]);
    @(negedge clk);
    check("R11 data held", 64'(out_data), 64'h0_0000_0F10);
    @(negedge clk);
    check("R11 data still held", 64'(out_data), 64'h0_0000_0F10);
    out_ready = 1'b1;
    #0;
    check("R10 ready when consumer ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 next accepted", 64'(out_data), 64'h0_0000_00AB);
    @(negedge clk);
    check("R10 empty", 64'(out_valid), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule